// File: doc/BRIEF.md
# Mirrored-Region Pointer Stepper

This block keeps a 10-bit access pointer and forms its next value for sequential fetches or stores. The low 9 bits form an address in a space split into three regions. A 64-word RAM appears twice at 0x000–0x07F. A 64-word ROM appears twice at 0x080–0x0FF. The upper half, 0x100–0x1FF, is I/O. When the pointer steps, it advances only inside the doubled region it is in. Stepping leaves an I/O address unchanged.

The top bit of the pointer is a mode flag and takes no part in decoding. Stepping carries it through unchanged, and only an explicit load changes it. The block drives this flag out as the enable for the arithmetic unit's carry latch. While the flag is set, add folds in the latched carry and captures the new carry-out. While it is clear, the latch is neither read nor written.

For the current pointer, the block also gives the decoded region, the 6-bit word index sent to the memories, and whether the address lies in the mirror copy.

Top module: `mra_addr_unit`

## Requirements
- R1: After reset the pointer is 0x000, the region is RAM, the word index is 0, the mirror flag is 0 and the carry enable is 0.
- R2: The region output is 2 (I/O) when address bit 8 is set. Otherwise it is 1 (ROM) when bit 7 is set, and otherwise 0 (RAM).
- R3: The word index is address bits 5:0. The mirror flag is address bit 6 when the region is RAM or ROM, and it is 0 in the I/O region.
- R4: A step from a RAM address adds one to bits 6:0 modulo 128 and keeps bits 9:7, so 0x03F goes to 0x040 and 0x07F goes to 0x000.
- R5: A step from a ROM address adds one to bits 6:0 modulo 128 and keeps bits 9:7, so 0x0FF goes to 0x080.
- R6: A step from an I/O address leaves the pointer unchanged.
- R7: Pointer bit 9 keeps its value through every step.
- R8: A load writes all 10 bits of the load value in the next cycle, and it takes priority over a step requested in the same cycle.
- R9: With neither load nor step requested, the pointer holds its value.
- R10: The carry-latch enable output equals pointer bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Load the pointer from load_val |
| load_val | input | 10 | New pointer value, bit 9 being the mode flag |
| step_en | input | 1 | Advance the pointer within its region |
| ptr_out | output | 10 | Current pointer |
| region_out | output | 2 | Region code: 0 RAM, 1 ROM, 2 I/O |
| word_idx | output | 6 | Word index sent to the memories |
| mirror_out | output | 1 | Address lies in the mirror copy of RAM or ROM |
| adc_en | output | 1 | Carry-latch enable for add-with-carry |

## Verification
A wrong pointer is visible at ptr_out in the cycle after the step or load that caused it. Region, index and mirror flag are decoded without a register, so a decode fault shows in the same cycle as the pointer that triggers it. A step that crosses the wrong boundary, such as 0x07F going to 0x080 or 0x0FF going to 0x100, moves the address into another region, and the region output shows this at once. A flag bit lost during a step shows on both ptr_out bit 9 and adc_en on the next cycle.

// File: rtl/mra_pkg.sv
`timescale 1ns/1ps
package mra_pkg;
    parameter int unsigned MRA_ADDR_W = 9;
    parameter int unsigned MRA_IDX_W  = 6;
    parameter int unsigned MRA_PTR_W  = MRA_ADDR_W + 1;

    typedef enum logic [1:0] {
        REG_RAM = 2'd0,
        REG_ROM = 2'd1,
        REG_IO  = 2'd2
    } region_e;
endpackage

// File: rtl/mra_region_decode.sv
`timescale 1ns/1ps
module mra_region_decode
    import mra_pkg::*;
#(
    parameter int unsigned ADDR_W = MRA_ADDR_W,
    parameter int unsigned IDX_W  = MRA_IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [IDX_W-1:0]  idx,
    output logic              mirror
);
    localparam int unsigned IO_BIT  = ADDR_W - 1;
    localparam int unsigned ROM_BIT = IDX_W + 1;
    localparam int unsigned MIR_BIT = IDX_W;

    always_comb begin
        if (addr[IO_BIT])       region = REG_IO;
        else if (addr[ROM_BIT]) region = REG_ROM;
        else                    region = REG_RAM;
        idx    = addr[IDX_W-1:0];
        mirror = addr[MIR_BIT] & ~addr[IO_BIT];
    end
endmodule

// File: rtl/mra_step_calc.sv
`timescale 1ns/1ps
module mra_step_calc
    import mra_pkg::*;
#(
    parameter int unsigned PTR_W  = MRA_PTR_W,
    parameter int unsigned ADDR_W = MRA_ADDR_W,
    parameter int unsigned IDX_W  = MRA_IDX_W
) (
    input  logic [PTR_W-1:0] cur,
    output logic [PTR_W-1:0] nxt
);
    localparam int unsigned SPAN_W = IDX_W + 1;
    localparam int unsigned IO_BIT = ADDR_W - 1;

    always_comb begin
        nxt = cur;
        if (!cur[IO_BIT]) begin
            nxt[SPAN_W-1:0] = cur[SPAN_W-1:0] + SPAN_W'(1);
        end
    end
endmodule

// File: rtl/mra_addr_unit.sv
`timescale 1ns/1ps
module mra_addr_unit
    import mra_pkg::*;
#(
    parameter int unsigned PTR_W  = MRA_PTR_W,
    parameter int unsigned ADDR_W = MRA_ADDR_W,
    parameter int unsigned IDX_W  = MRA_IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [PTR_W-1:0] load_val,
    input  logic             step_en,
    output logic [PTR_W-1:0] ptr_out,
    output logic [1:0]       region_out,
    output logic [IDX_W-1:0] word_idx,
    output logic             mirror_out,
    output logic             adc_en
);
    localparam int unsigned FLAG_BIT = PTR_W - 1;
    localparam int unsigned IO_BIT   = ADDR_W - 1;
    localparam int unsigned ROM_BIT  = IDX_W + 1;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } state_t;

    state_t           st_d, st_q;
    logic [PTR_W-1:0] step_nxt_d;
    region_e          region_d;

    mra_step_calc #(.PTR_W(PTR_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_step (
        .cur (st_q.ptr),
        .nxt (step_nxt_d)
    );

    mra_region_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
        .addr   (st_q.ptr[ADDR_W-1:0]),
        .region (region_d),
        .idx    (word_idx),
        .mirror (mirror_out)
    );

    always_comb begin
        st_d = st_q;
        if (load_en)      st_d.ptr = load_val;
        else if (step_en) st_d.ptr = step_nxt_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr_out    = st_q.ptr;
    assign region_out = region_d;
    assign adc_en     = st_q.ptr[FLAG_BIT];

    // Stepping outside I/O never leaves the region
    assert_stay_in_region_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load_en && !ptr_out[IO_BIT])
        |=> (ptr_out[IO_BIT:ROM_BIT] == $past(ptr_out[IO_BIT:ROM_BIT])));

    assert_io_frozen_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load_en && ptr_out[IO_BIT]) |=> $stable(ptr_out));

    assert_flag_kept_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en) |=> $stable(adc_en));

    assert_load_wins_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (ptr_out == $past(load_val)));

    assert_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !step_en) |=> $stable(ptr_out));

    assert_io_region_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        (region_out == 2'd2) == ptr_out[IO_BIT]);
endmodule

// File: tb/mra_addr_unit_bench.sv
`timescale 1ns/1ps
module mra_addr_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_en = 1'b0;
    logic [9:0] load_val = '0;
    logic       step_en = 1'b0;
    logic [9:0] ptr_out;
    logic [1:0] region_out;
    logic [5:0] word_idx;
    logic       mirror_out;
    logic       adc_en;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    bit          done = 1'b0;
    logic [9:0]  exp_ptr;

    always #2 clk = ~clk;

    mra_addr_unit u_mra_addr_unit (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(load_val),
        .step_en(step_en), .ptr_out(ptr_out), .region_out(region_out),
        .word_idx(word_idx), .mirror_out(mirror_out), .adc_en(adc_en)
    );

    function automatic logic [9:0] ref_step(input logic [9:0] v);
        logic [6:0] low;
        if (v >= 10'h100 && v < 10'h200) return v;
        if (v >= 10'h300) return v;
        low = v[6:0] + 7'd1;
        return {v[9:7], low};
    endfunction

    function automatic logic [1:0] ref_region(input logic [9:0] v);
        logic [8:0] a = v[8:0];
        if (a >= 9'h100) return 2'd2;
        if (a >= 9'h080) return 2'd1;
        return 2'd0;
    endfunction

    function automatic logic ref_mirror(input logic [9:0] v);
        logic [8:0] a = v[8:0];
        if (a >= 9'h100) return 1'b0;
        return (a % 9'h080) >= 9'h040;
    endfunction

    task automatic check(input logic [9:0] e, input string req);
        logic [20:0] act, exp;
        act = {ptr_out, region_out, word_idx, mirror_out, adc_en};
        exp = {e, ref_region(e), e[5:0], ref_mirror(e), e[9]};
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: ptr=%h reg=%0d idx=%h mir=%b adc=%b expected ptr=%h reg=%0d idx=%h mir=%b adc=%b",
                     req, ptr_out, region_out, word_idx, mirror_out, adc_en,
                     e, ref_region(e), e[5:0], ref_mirror(e), e[9]);
        end
    endtask

    task automatic cyc(input logic ld, input logic [9:0] v, input logic st);
        @(negedge clk);
        load_en = ld; load_val = v; step_en = st;
        if (ld) exp_ptr = v;
        else if (st) exp_ptr = ref_step(exp_ptr);
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd1234));
        exp_ptr = '0;
        repeat (3) @(posedge clk);
        #1;
        check(10'h000, "R1");
        rst_n = 1'b1;

        // Full sweep: every pointer value, both flag values
        for (int v = 0; v < 1024; v++) begin
            cyc(1'b1, 10'(v), 1'b0);
            check(exp_ptr, "R8 R2 R3 R10");
            cyc(1'b0, 10'h000, 1'b1);
            if (v[8])      check(exp_ptr, "R6 R7");
            else if (v[7]) check(exp_ptr, "R5 R7");
            else           check(exp_ptr, "R4 R7");
        end

        // Directed boundaries
        cyc(1'b1, 10'h03F, 1'b0); cyc(1'b0, 0, 1'b1); check(10'h040, "R4 mirror entry");
        cyc(1'b1, 10'h07F, 1'b0); cyc(1'b0, 0, 1'b1); check(10'h000, "R4 wrap");
        cyc(1'b1, 10'h27F, 1'b0); cyc(1'b0, 0, 1'b1); check(10'h200, "R4 R7 wrap flag");
        cyc(1'b1, 10'h0FF, 1'b0); cyc(1'b0, 0, 1'b1); check(10'h080, "R5 wrap");
        cyc(1'b1, 10'h3FF, 1'b0); cyc(1'b0, 0, 1'b1); check(10'h3FF, "R6 top");
        cyc(1'b1, 10'h100, 1'b0); cyc(1'b0, 0, 1'b1); check(10'h100, "R6 base");
        cyc(1'b1, 10'h0C5, 1'b1); check(10'h0C5, "R8 priority");
        cyc(1'b0, 10'h155, 1'b0); check(10'h0C5, "R9 hold");
        cyc(1'b0, 10'h000, 1'b0); check(10'h0C5, "R9 hold again");

        // Constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            logic ld, st;
            ld = ($urandom % 8) == 0;
            st = ($urandom % 2) == 0;
            cyc(ld, 10'($urandom), st);
            check(exp_ptr, ld ? "R8" : (st ? "R4 R5 R6 R7" : "R9"));
        end

        done = 1'b1;
        summary();
    end
endmodule